// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block holds the 32-bit status and control word for one root port of a USB host controller. Software writes it over a simple memory-mapped write strobe and reads it back combinationally. A port model drives pulses for device attach and detach, a level that says whether the attached device supports high speed, and a level for the port's over-current condition.

The register merges two sources of change in one update. Software writes are applied first:

- Change flags are cleared by writing one to them.
- Control bits are written directly.
- The port-enable bit can be cleared by software but never set by it.

Hardware events are then applied on top of the written value. When software ends a port reset, the port is enabled only if a high-speed-capable device is connected. A detach drops both the connection and the enable, and flags the change.

Top module: `psr_port_status`

## Requirements
- R1: Synchronous active-low reset loads 0x00001000: port power (bit 12) is 1 and every other bit is 0.
- R2: Bits 1 (connect change), 3 (enable change) and 5 (over-current change) clear when a write has a 1 in that position. A 0 in a write leaves them unchanged.
- R3: On a write, bits 6, 7, 8, 13, 20, 21 and 22 (mask 0x007021C0) take the written value directly. Bit 8 is port reset, bit 21 is wake-on-disconnect enable and bit 22 is wake-on-over-current enable.
- R4: Bits outside 0x007021C0 and outside the clear-on-one set keep their hardware-maintained value across any write. This covers bits 0, 4 and 12, and the unused bits, which stay 0.
- R5: Writing 0 to port enable (bit 2) clears it without setting bit 3. Writing 1 to bit 2 never sets it.
- R6: A detach pulse clears bits 0 and 2 and sets bit 1. Bit 3 is also set if the port was enabled, and stays unchanged otherwise.
- R7: An attach pulse sets bits 0 and 1 and leaves bit 2 unchanged. When an attach and a write clearing bit 1 happen in the same cycle, the attach wins and bit 1 ends up set.
- R8: A write that takes bit 8 from 1 to 0 sets bit 2 when bit 0 is 1 and the high-speed input is 1. Otherwise bit 2 is left as it was.
- R9: Bit 4 follows the over-current input one cycle later. Any change of that input sets bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register value |
| attach_i | input | 1 | One-cycle device attach pulse |
| detach_i | input | 1 | One-cycle device detach pulse |
| hs_cap_i | input | 1 | Attached device is high-speed capable |
| oc_i | input | 1 | Over-current condition level |

## Verification
The assertions assume that attach and detach never pulse in the same cycle. They also assume that a detach only follows an attach, so a write clearing bit 1 is seen alone only when no event is present. The stimulus table drives at most one event per row and leaves the over-current level unchanged except in rows meant to toggle it. The directed tests that combine a write with an event pick pairs whose outcome is fixed by the event-after-write order.

// File: rtl/psr_pkg.sv
// Package: bit positions and masks shared by the port status register blocks.
// Assumes a 32-bit register with the fixed positions software decodes.
package psr_pkg;
    localparam int REG_W      = 32;
    localparam int B_CONN     = 0;
    localparam int B_CONN_CHG = 1;
    localparam int B_EN       = 2;
    localparam int B_EN_CHG   = 3;
    localparam int B_OC       = 4;
    localparam int B_OC_CHG   = 5;
    localparam int B_RESET    = 8;
    localparam int B_POWER    = 12;
    localparam logic [REG_W-1:0] CLR1_MASK  = 32'h0000_002A;
    localparam logic [REG_W-1:0] SW_MASK    = 32'h0070_21C0;
    localparam logic [REG_W-1:0] RESET_VAL  = 32'h0000_1000;
endpackage

// File: rtl/psr_sw_merge.sv
// Module: applies one software write to the register value.
// Order: clear-on-one flags, then enable clear, then direct software bits.
// Also flags the end of a port reset (reset bit written from 1 to 0).
// Assumes the caller applies hardware events after this stage.
module psr_sw_merge
    import psr_pkg::*;
#(
    parameter int W = REG_W,
    parameter logic [W-1:0] CLR_M = CLR1_MASK,
    parameter logic [W-1:0] DIR_M = SW_MASK
) (
    input  logic [W-1:0] cur_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] next_o,
    output logic         rst_end_o
);
    localparam logic [W-1:0] EN_M = W'(1) << B_EN;

    logic [W-1:0] after_clr;
    logic [W-1:0] after_en;

    // Purpose: staged write merge in the fixed order.
    always_comb begin
        after_clr = cur_i & ~(wr_data_i & CLR_M);
        after_en  = after_clr & (wr_data_i | ~EN_M);
        next_o    = wr_en_i ? ((after_en & ~DIR_M) | (wr_data_i & DIR_M)) : cur_i;
        rst_end_o = wr_en_i && cur_i[B_RESET] && !wr_data_i[B_RESET];
    end
endmodule

// File: rtl/psr_hw_events.sv
// Module: applies hardware-side events on top of the post-write value.
// Order: reset-end enable, over-current tracking, attach, detach (last wins).
// Assumes attach and detach never pulse in the same cycle.
module psr_hw_events
    import psr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] val_i,
    input  logic         rst_end_i,
    input  logic         hs_cap_i,
    input  logic         attach_i,
    input  logic         detach_i,
    input  logic         oc_i,
    output logic [W-1:0] val_o
);
    // Purpose: event overlay in priority order.
    always_comb begin
        val_o = val_i;
        if (rst_end_i && val_i[B_CONN] && hs_cap_i) begin
            val_o[B_EN] = 1'b1;
        end
        if (oc_i != val_i[B_OC]) begin
            val_o[B_OC]     = oc_i;
            val_o[B_OC_CHG] = 1'b1;
        end
        if (attach_i) begin
            val_o[B_CONN]     = 1'b1;
            val_o[B_CONN_CHG] = 1'b1;
        end
        if (detach_i) begin
            if (val_o[B_EN]) begin
                val_o[B_EN_CHG] = 1'b1;
            end
            val_o[B_CONN]     = 1'b0;
            val_o[B_EN]       = 1'b0;
            val_o[B_CONN_CHG] = 1'b1;
        end
    end
endmodule

// File: rtl/psr_port_status.sv
// Module: top of the per-port status register; holds the state word.
// Assumes single-cycle event pulses and a combinational read path.
module psr_port_status
    import psr_pkg::*;
#(
    parameter int W = REG_W,
    parameter logic [W-1:0] RST_V = RESET_VAL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rd_data_o,
    input  logic         attach_i,
    input  logic         detach_i,
    input  logic         hs_cap_i,
    input  logic         oc_i
);
    logic [W-1:0] port_q;
    logic [W-1:0] written;
    logic [W-1:0] port_d;
    logic         rst_end;

    psr_sw_merge #(.W(W)) u_merge (
        .cur_i(port_q), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .next_o(written), .rst_end_o(rst_end)
    );

    psr_hw_events #(.W(W)) u_events (
        .val_i(written), .rst_end_i(rst_end), .hs_cap_i(hs_cap_i),
        .attach_i(attach_i), .detach_i(detach_i), .oc_i(oc_i),
        .val_o(port_d)
    );

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= RST_V;
        else        port_q <= port_d;
    end

    assign rd_data_o = port_q;

    // Input assumption: attach and detach are exclusive.
    a_in_exclusive_events: assert property (@(posedge clk) disable iff (!rst_n)
        !(attach_i && detach_i));

    a_r2_clear_conn_chg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[B_CONN_CHG] && !attach_i && !detach_i) |=> !port_q[B_CONN_CHG]);

    a_r3_direct_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((port_q & SW_MASK) == ($past(wr_data_i) & SW_MASK)));

    a_r4_power_held: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(port_q[B_POWER]));

    a_r5_r8_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_q[B_EN]) |-> ($past(wr_en_i) && $past(port_q[B_RESET]) &&
                                 !port_q[B_RESET] && $past(hs_cap_i)));

    a_r6_detach: assert property (@(posedge clk) disable iff (!rst_n)
        detach_i |=> (!port_q[B_CONN] && !port_q[B_EN] && port_q[B_CONN_CHG]));

    a_r7_attach: assert property (@(posedge clk) disable iff (!rst_n)
        (attach_i && !detach_i) |=> (port_q[B_CONN] && port_q[B_CONN_CHG]));

    a_r9_overcurrent: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_i != port_q[B_OC]) |=> ((port_q[B_OC] == $past(oc_i)) && port_q[B_OC_CHG]));
endmodule

// File: tb/psr_port_status_bench.sv
// Bench: vector table walk followed by directed reset and corner tests.
module psr_port_status_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        attach, detach, hs_cap, oc;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    psr_port_status u_psr_port_status (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .attach_i(attach), .detach_i(detach),
        .hs_cap_i(hs_cap), .oc_i(oc)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] data;
        logic        att;
        logic        det;
        logic        hs;
        logic        ocl;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1000, 8'd1}, // R1 idle
        '{1'b0, 32'h0,        1'b1,1'b0,1'b1,1'b0, 32'h0000_1003, 8'd7}, // R7 attach
        '{1'b1, 32'h2,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1001, 8'd2}, // R2 clear bit1
        '{1'b1, 32'h104,      1'b0,1'b0,1'b1,1'b0, 32'h0000_1101, 8'd5}, // R5 no sw set
        '{1'b1, 32'h0,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1005, 8'd8}, // R8 hs enable
        '{1'b1, 32'h4,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1005, 8'd4}, // R4 held
        '{1'b1, 32'h0070_21C4,1'b0,1'b0,1'b1,1'b0, 32'h0070_31C5, 8'd3}, // R3 set sw bits
        '{1'b1, 32'hFF8F_DE3F,1'b0,1'b0,1'b1,1'b0, 32'h0000_1005, 8'd4}, // R4 others held
        '{1'b1, 32'h0,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1001, 8'd5}, // R5 sw clear
        '{1'b0, 32'h0,        1'b0,1'b0,1'b1,1'b1, 32'h0000_1031, 8'd9}, // R9 oc rise
        '{1'b1, 32'h20,       1'b0,1'b0,1'b1,1'b1, 32'h0000_1011, 8'd2}, // R2 clear bit5
        '{1'b0, 32'h0,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1021, 8'd9}, // R9 oc fall
        '{1'b1, 32'h20,       1'b0,1'b0,1'b1,1'b0, 32'h0000_1001, 8'd2}, // R2
        '{1'b1, 32'h100,      1'b0,1'b0,1'b0,1'b0, 32'h0000_1101, 8'd3}, // R3 reset on
        '{1'b1, 32'h0,        1'b0,1'b0,1'b0,1'b0, 32'h0000_1001, 8'd8}, // R8 not hs
        '{1'b1, 32'h100,      1'b0,1'b0,1'b1,1'b0, 32'h0000_1101, 8'd3}, // R3
        '{1'b1, 32'h0,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1005, 8'd8}, // R8
        '{1'b0, 32'h0,        1'b0,1'b1,1'b1,1'b0, 32'h0000_100A, 8'd6}, // R6 detach enabled
        '{1'b1, 32'hA,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1000, 8'd2}, // R2
        '{1'b1, 32'h100,      1'b0,1'b0,1'b1,1'b0, 32'h0000_1100, 8'd3}, // R3
        '{1'b1, 32'h0,        1'b0,1'b0,1'b1,1'b0, 32'h0000_1000, 8'd8}  // R8 no device
    };

    task automatic check(input logic [31:0] exp, input int req);
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %08h expected %08h", req, rd_data, exp);
        end
    endtask

    // Drive one cycle at negedge, let the edge register it, check at next negedge.
    task automatic step(input logic w, input logic [31:0] d, input logic a,
                        input logic dt, input logic h, input logic o);
        wr_en = w; wr_data = d; attach = a; detach = dt; hs_cap = h; oc = o;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; attach = 1'b0; detach = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        attach = 1'b0; detach = 1'b0; hs_cap = 1'b1; oc = 1'b0;
        repeat (3) @(negedge clk);
        check(32'h0000_1000, 1); // R1 reset value
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wr, VECS[i].data, VECS[i].att, VECS[i].det,
                 VECS[i].hs, VECS[i].ocl);
            check(VECS[i].exp, int'(VECS[i].req));
        end
        // R6: detach while not enabled leaves bit3 clear
        step(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
        check(32'h0000_1003, 7);
        step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0);
        check(32'h0000_1002, 6);
        // R7: attach with simultaneous write-clear of bit1 keeps bit1 set
        step(1'b1, 32'h2, 1'b1, 1'b0, 1'b1, 1'b0);
        check(32'h0000_1003, 7);
        // R1: reset mid-operation restores reset value
        step(1'b1, 32'h0060_0040, 1'b0, 1'b0, 1'b1, 1'b0);
        check(32'h0060_1043, 3);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(32'h0000_1000, 1);
        rst_n = 1'b1;
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(32'h0000_1000, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule